// File: doc/BRIEF.md
# Debounced GPIO Input Status Register

This block watches a bank of general-purpose pins that are not synchronous to the system clock and turns them into clean levels that software can read. Each pin first passes through a two-flop synchronizer. A free-running counter then produces a slow scan tick, nominally every 25 ms. On each tick the block moves the previous sample aside and takes a new one. A pin's accepted level changes only when the two stored samples agree, so a change that lasts a single scan is treated as bounce. A per-pin bypass mask lets chosen pins skip the scan filter and follow their synchronized input directly. A pin that is configured as an output reports the level it is driving rather than its input.

Software reads the levels through a byte-wide register port. Each status byte is backed by a latched snapshot with read-twice-to-clear behaviour. A read returns the snapshot. When a read of a status byte directly follows a read of that same byte, it also reloads the snapshot from the live level. Any other access between the two reads starts the pair again. The mask bytes can be both written and read back at their own addresses.

Top module: `gpin_status_top`

## Requirements
- R1: After reset, every implemented pin's status bit reads 1 and every mask bit reads 0.
- R2: Status byte b sits at address 0x10+b and mask byte b at 0x18+b. Bit i of byte b belongs to pin 8b+i. Bits above the last pin read 0. A read's data appears on `bus_rdata` one cycle after the access. Any address that is not mapped reads 0.
- R3: With its mask bit at 0, a pin's accepted level takes a new value only when the previous and current scan samples agree. A pulse that lasts one scan period leaves the accepted level unchanged.
- R4: The scan tick fires once every `SCAN_CYCLES` clocks. A stable input change reaches the accepted level no sooner than one scan period and no later than two scan periods plus a few cycles.
- R5: With its mask bit at 1, a pin's accepted level follows its synchronized input within three clocks, with no wait for a scan.
- R6: A pin with `pin_is_out` high reports `pin_drive` in its status bit, whatever its input level.
- R7: A read of a status byte returns the latched snapshot. A read of a status byte that directly follows a read of the same byte returns the snapshot and then reloads it from the live level. The next read starts a new pair.
- R8: Any write, or any read of another address, between two reads of a status byte restarts the pair, so no reload takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | NUM_PINS | Pin levels, not synchronous to clk |
| pin_is_out | input | NUM_PINS | 1 marks a pin as an output |
| pin_drive | input | NUM_PINS | Level driven on output pins |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
The bench sends pulses exactly one scan long at several tick phases. It watches the status with back-to-back reads, so a design that accepted a lone sample would show a transient flip. It measures the latency of a stable change at several phases against the window from one to two scan periods, which exposes a design that only compares after a third scan. Reads of the same byte are interleaved with reads of the other byte and with a write. A design that ignored the interruption would reload early and return the new level one read too soon. Walking-one and walking-zero sweeps, output-pin drive sweeps and bypass timing cover the bit mapping and the padding bits.

// File: rtl/gpin_pkg.sv
package gpin_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned BYTE_W = 8;
  // status bytes live in 0x10..0x17, mask bytes in 0x18..0x1F
  localparam logic [1:0] STAT_PAGE = 2'b10;
  localparam logic [1:0] MASK_PAGE = 2'b11;

  function automatic int unsigned byte_count(input int unsigned pins);
    return (pins + 7) / 8;
  endfunction
endpackage

// File: rtl/gpin_scan_timer.sv
module gpin_scan_timer #(
  parameter int unsigned SCAN_CYCLES = 1_250_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (SCAN_CYCLES > 1) ? $clog2(SCAN_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SCAN_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/gpin_debounce_bank.sv
module gpin_debounce_bank #(
  parameter int unsigned N         = 24,
  parameter bit          RST_LEVEL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] bypass,
  output logic [N-1:0] sync_lvl,
  output logic [N-1:0] prev_s,
  output logic [N-1:0] cur_s,
  output logic [N-1:0] acc
);
  logic [N-1:0] meta;
  logic         tick_d;   // compare one cycle after the samples shift

  always_ff @(posedge clk) begin
    if (rst) tick_d <= 1'b0;
    else     tick_d <= tick;
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        meta[i]     <= RST_LEVEL;
        sync_lvl[i] <= RST_LEVEL;
        prev_s[i]   <= RST_LEVEL;
        cur_s[i]    <= RST_LEVEL;
        acc[i]      <= RST_LEVEL;
      end else begin
        meta[i]     <= pin_in[i];
        sync_lvl[i] <= meta[i];
        if (tick) begin
          prev_s[i] <= cur_s[i];
          cur_s[i]  <= sync_lvl[i];
        end
        if (bypass[i])
          acc[i] <= sync_lvl[i];
        else if (tick_d && (prev_s[i] == cur_s[i]))
          acc[i] <= cur_s[i];
      end
    end
  end
endmodule

// File: rtl/gpin_status_regs.sv
module gpin_status_regs
  import gpin_pkg::*;
#(
  parameter int unsigned N         = 24,
  parameter bit          RST_LEVEL = 1'b1,
  localparam int unsigned NB       = byte_count(N),
  localparam int unsigned PAD_W    = NB * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [N-1:0]      live,
  output logic [N-1:0]      mask,
  output logic [PAD_W-1:0]  latch
);
  function automatic logic [PAD_W-1:0] valid_bits();
    logic [PAD_W-1:0] v;
    for (int i = 0; i < PAD_W; i++) v[i] = (i < N);
    return v;
  endfunction

  localparam logic [PAD_W-1:0] VALID = valid_bits();

  logic [PAD_W-1:0]  mask_q;
  logic [PAD_W-1:0]  live_pad;
  logic [2:0]        idx;
  logic              in_range;
  logic              is_stat;
  logic              is_mask;
  logic              armed;
  logic [ADDR_W-1:0] last_addr;

  assign live_pad = PAD_W'(live) & VALID;
  assign idx      = bus_addr[2:0];
  assign in_range = 32'(idx) < NB;
  assign is_stat  = (bus_addr[4:3] == STAT_PAGE) && in_range;
  assign is_mask  = (bus_addr[4:3] == MASK_PAGE) && in_range;
  assign mask     = mask_q[N-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      mask_q    <= '0;
      latch     <= VALID & {PAD_W{RST_LEVEL}};
      armed     <= 1'b0;
      last_addr <= '0;
    end else if (bus_sel) begin
      if (bus_we) begin
        armed <= 1'b0;
        if (is_mask)
          mask_q[idx*BYTE_W +: BYTE_W] <= bus_wdata & VALID[idx*BYTE_W +: BYTE_W];
      end else begin
        if (is_stat)      bus_rdata <= latch[idx*BYTE_W +: BYTE_W];
        else if (is_mask) bus_rdata <= mask_q[idx*BYTE_W +: BYTE_W];
        else              bus_rdata <= '0;
        if (is_stat) begin
          if (armed && (last_addr == bus_addr)) begin
            latch[idx*BYTE_W +: BYTE_W] <= live_pad[idx*BYTE_W +: BYTE_W];
            armed <= 1'b0;
          end else begin
            armed     <= 1'b1;
            last_addr <= bus_addr;
          end
        end else begin
          armed <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/gpin_status_top.sv
module gpin_status_top
  import gpin_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 24,
  parameter int unsigned SCAN_CYCLES = 1_250_000,
  parameter bit          RST_LEVEL   = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] pin_is_out,
  input  logic [NUM_PINS-1:0] pin_drive,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [4:0]          bus_addr,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata
);
  localparam int unsigned NB    = byte_count(NUM_PINS);
  localparam int unsigned PAD_W = NB * BYTE_W;

  logic                scan_tick;
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] smp_prev;
  logic [NUM_PINS-1:0] smp_cur;
  logic [NUM_PINS-1:0] acc_lvl;
  logic [NUM_PINS-1:0] dbdis_mask;
  logic [NUM_PINS-1:0] live_lvl;
  logic [PAD_W-1:0]    stat_latch;

  gpin_scan_timer #(.SCAN_CYCLES(SCAN_CYCLES)) u_timer (
    .clk (clk),
    .rst (rst),
    .tick(scan_tick)
  );

  gpin_debounce_bank #(.N(NUM_PINS), .RST_LEVEL(RST_LEVEL)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .tick    (scan_tick),
    .pin_in  (pin_in),
    .bypass  (dbdis_mask),
    .sync_lvl(pin_sync),
    .prev_s  (smp_prev),
    .cur_s   (smp_cur),
    .acc     (acc_lvl)
  );

  // output pins report what they drive
  assign live_lvl = (pin_is_out & pin_drive) | (~pin_is_out & acc_lvl);

  gpin_status_regs #(.N(NUM_PINS), .RST_LEVEL(RST_LEVEL)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .live     (live_lvl),
    .mask     (dbdis_mask),
    .latch    (stat_latch)
  );
endmodule

// File: rtl/gpin_status_chk.sv
module gpin_status_chk #(
  parameter int unsigned N           = 24,
  parameter int unsigned SCAN_CYCLES = 1_250_000,
  localparam int unsigned NB         = (N + 7) / 8,
  localparam int unsigned PAD_W      = NB * 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_sel,
  input logic             bus_we,
  input logic [4:0]       bus_addr,
  input logic [7:0]       bus_rdata,
  input logic             tick,
  input logic [N-1:0]     sync_lvl,
  input logic [N-1:0]     prev_s,
  input logic [N-1:0]     cur_s,
  input logic [N-1:0]     acc,
  input logic [N-1:0]     mask,
  input logic [PAD_W-1:0] latch
);
  int unsigned since;
  logic        seen;
  logic        unmapped;

  always_ff @(posedge clk) begin
    if (rst) begin
      since <= 0;
      seen  <= 1'b0;
    end else if (tick) begin
      since <= 0;
      seen  <= 1'b1;
    end else begin
      since <= since + 1;
    end
  end

  assign unmapped = !((bus_addr[4] == 1'b1) && (32'(bus_addr[2:0]) < NB));

  p_reset_mask_r1: assert property (@(posedge clk) rst |=> (mask == '0));

  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (rst)
    $past(bus_sel && !bus_we && unmapped) |-> (bus_rdata == 8'h00));

  p_agree_only_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((acc ^ $past(acc)) & ~$past(mask) & ($past(prev_s) ^ $past(cur_s))) == '0));

  p_accept_value_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((acc ^ $past(acc)) & ~$past(mask) & (acc ^ $past(cur_s))) == '0));

  p_scan_period_r4: assert property (@(posedge clk) disable iff (rst)
    tick |-> (seen ? (since == SCAN_CYCLES - 1) : (since == SCAN_CYCLES)));

  p_scan_due_r4: assert property (@(posedge clk) disable iff (rst)
    since <= SCAN_CYCLES);

  p_bypass_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((acc ^ $past(sync_lvl)) & $past(mask)) == '0));

  p_reload_on_read_r7: assert property (@(posedge clk) disable iff (rst)
    (latch != $past(latch)) |-> $past(bus_sel && !bus_we));
endmodule

bind gpin_status_top gpin_status_chk #(.N(NUM_PINS), .SCAN_CYCLES(SCAN_CYCLES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_sel  (bus_sel),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .tick     (scan_tick),
  .sync_lvl (pin_sync),
  .prev_s   (smp_prev),
  .cur_s    (smp_cur),
  .acc      (acc_lvl),
  .mask     (dbdis_mask),
  .latch    (stat_latch)
);

// File: tb/gpin_status_top_tb.sv
module gpin_status_top_tb;
  localparam int NP = 12;
  localparam int SC = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pin_in = '1;
  logic [NP-1:0] pin_is_out = '0;
  logic [NP-1:0] pin_drive = '0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;

  int n_checks = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 1'b0;

  gpin_status_top #(.NUM_PINS(NP), .SCAN_CYCLES(SC)) u_dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .pin_is_out(pin_is_out),
    .pin_drive(pin_drive), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic check_range(input string req, input int got, input int lo, input int hi);
    n_checks++;
    if (got < lo || got > hi) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d..%0d", req, got, lo, hi);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  // returns the live level of a status byte: disarm, then three reads
  task automatic peek(input logic [4:0] a, output logic [7:0] d);
    logic [7:0] t;
    rd(5'h00, t);
    rd(a, t);
    rd(a, t);
    rd(a, d);
  endtask

  function automatic logic [7:0] byte_of(input logic [NP-1:0] p, input int b);
    logic [15:0] w;
    w = 16'(p);
    return w[b*8 +: 8];
  endfunction

  // time from a pin change until back-to-back reads of 0x10 show the new value
  task automatic measure(input int bitn, input logic newv, output int lat);
    logic [7:0] d;
    int t0;
    bit hit;
    t0 = cyc;
    pin_in[bitn] = newv;
    hit = 1'b0;
    lat = 9999;
    for (int k = 0; k < 60 && !hit; k++) begin
      rd(5'h10, d);
      if (d[bitn] == newv) begin
        hit = 1'b1;
        lat = cyc - t0;
      end
    end
  endtask

  initial begin
    wait_cyc(100000);
    if (!done) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [NP-1:0] p;
    int lat;
    int bad;

    wait_cyc(5);
    rst = 1'b0;

    // R1 reset state, R2 padding bits
    rd(5'h10, d); check("R1 status byte0", d, 8'hFF);
    rd(5'h11, d); check("R1 R2 status byte1 pad", d, 8'h0F);
    rd(5'h18, d); check("R1 mask byte0", d, 8'h00);
    rd(5'h19, d); check("R1 mask byte1", d, 8'h00);

    // R2 unmapped addresses
    rd(5'h05, d); check("R2 unmapped 0x05", d, 8'h00);
    rd(5'h12, d); check("R2 unmapped 0x12", d, 8'h00);
    rd(5'h1A, d); check("R2 unmapped 0x1A", d, 8'h00);

    // R7 read-twice behaviour
    pin_in = 12'h0A5;
    wait_cyc(4*SC);
    rd(5'h00, d);
    rd(5'h10, d); check("R7 first read keeps snapshot", d, 8'hFF);
    rd(5'h10, d); check("R7 second read returns old snapshot", d, 8'hFF);
    rd(5'h10, d); check("R7 read after reload", d, 8'hA5);
    rd(5'h10, d); check("R7 new pair first read", d, 8'hA5);

    // R8 interruption by another status read
    pin_in = 12'h05A;
    wait_cyc(4*SC);
    rd(5'h00, d);
    rd(5'h10, d); check("R8 byte0 snapshot", d, 8'hA5);
    rd(5'h11, d); check("R8 byte1 never reloaded", d, 8'h0F);
    rd(5'h10, d); check("R8 no reload after other read", d, 8'hA5);
    rd(5'h10, d); check("R8 pair second read", d, 8'hA5);
    rd(5'h10, d); check("R8 fresh after pair", d, 8'h5A);

    // R8 interruption by a write
    pin_in = 12'h0C3;
    wait_cyc(4*SC);
    rd(5'h00, d);
    rd(5'h10, d); check("R8 before write", d, 8'h5A);
    wr(5'h19, 8'h00);
    rd(5'h10, d); check("R8 write restarts pair a", d, 8'h5A);
    rd(5'h10, d); check("R8 write restarts pair b", d, 8'h5A);
    rd(5'h10, d); check("R8 reload after clean pair", d, 8'hC3);

    // R3 R2 walking sweeps: settled level and bit mapping
    for (int w = 0; w < 2; w++) begin
      for (int i = 0; i < NP; i++) begin
        p = (w == 0) ? NP'(1 << i) : ~NP'(1 << i);
        pin_in = p;
        wait_cyc(3*SC + 10);
        peek(5'h10, d); check("R3 R2 sweep byte0", d, byte_of(p, 0));
        peek(5'h11, d); check("R3 R2 sweep byte1", d, byte_of(p, 1));
      end
    end

    // R4 latency at several phases and both directions
    pin_in = '1;
    wait_cyc(4*SC);
    for (int ph = 0; ph < 6; ph++) begin
      wait_cyc(ph * 3 + 1);
      measure(ph % 8, 1'b0, lat);
      check_range("R4 latency fall", lat, SC, 2*SC + 14);
      wait_cyc(3*SC);
      wait_cyc(ph + 2);
      measure(ph % 8, 1'b1, lat);
      check_range("R4 latency rise", lat, SC, 2*SC + 14);
      wait_cyc(3*SC);
    end

    // R3 single-scan pulses must never appear
    for (int ph = 0; ph < 5; ph++) begin
      wait_cyc(ph * 5 + 1);
      bad = 0;
      fork
        begin
          pin_in[3] = 1'b0;
          wait_cyc(SC);
          pin_in[3] = 1'b1;
        end
        begin
          for (int k = 0; k < 2*SC + 8; k++) begin
            logic [7:0] m;
            rd(5'h10, m);
            if (m[3] !== 1'b1) bad++;
          end
        end
      join
      check("R3 one-scan pulse rejected", bad, 0);
    end

    // R5 bypass mask, R2 mask readback with padding
    wr(5'h18, 8'h01);
    rd(5'h18, d); check("R2 mask byte0 readback", d, 8'h01);
    wr(5'h19, 8'hFF);
    rd(5'h19, d); check("R2 mask byte1 pad", d, 8'h0F);
    wr(5'h19, 8'h00);
    wait_cyc(2);
    measure(0, 1'b0, lat);
    check_range("R5 bypass fall", lat, 1, 12);
    wait_cyc(5);
    measure(0, 1'b1, lat);
    check_range("R5 bypass rise", lat, 1, 12);
    wr(5'h18, 8'h00);

    // R6 output pins report the driven level
    pin_is_out = 12'h00F;
    for (int v = 0; v < 16; v++) begin
      pin_drive = NP'(v);
      peek(5'h10, d); check("R6 drive over high inputs", d, 8'hF0 | v);
    end
    pin_in = '0;
    wait_cyc(4*SC);
    pin_drive = 12'h005;
    peek(5'h10, d); check("R6 drive over low inputs", d, 8'h05);
    pin_is_out = '0;
    peek(5'h10, d); check("R6 inputs again", d, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule